// File: doc/BRIEF.md
# Resynchronizable Antenna-Carrier Transmit Buffer

This block holds one channel's 32-bit antenna-carrier samples between the data source and the frame mapper, in a circular store. The data source pulses `resync` once it has seen the start pulse from the frame-timing logic. The pulse resets the write side to slot zero, so the whole store is free for the new burst. A sample offered in that same cycle is kept in slot zero.

The read side takes no samples until a frame-reference pulse has armed it. After the pulse it lets a programmable number of mapper word strobes pass unanswered, then serves one sample per strobe. Two flags latch trouble and stay set until the next resync. The overflow flag latches a write that would overwrite unread data. The underflow flag latches a served strobe that found the store empty.

Top module: `axc_tx_buffer`

## Requirements
- R1: After reset `rd_valid`, `ovf_flag` and `udf_flag` are 0, and strobes on `rd_req` return no data until a `frame_ref` pulse has armed the read side.
- R2: Samples accepted on `wr_data` while `wr_valid` is 1 come out on `rd_data` in the order they were written, all 32 bits intact.
- R3: A cycle with `resync` = 1 returns the write position to slot zero. If `wr_valid` is 1 in that cycle, that sample goes into slot zero and becomes the first sample read afterwards. If `wr_valid` is 0, the next accepted write goes into slot zero.
- R4: `resync` discards all unread samples and clears the read position. It also returns the read side to its unarmed state, so a new `frame_ref` is needed before reads resume.
- R5: After a `frame_ref` pulse, the first `map_offset` strobes produce nothing and set no flag. The strobe that follows them, and every later strobe, is served.
- R6: A served strobe that finds data makes `rd_valid` 1 in the next cycle, with the oldest unread sample on `rd_data`.
- R7: A write while DEPTH samples are held, with no served read in the same cycle, is dropped and sets `ovf_flag`.
- R8: A served strobe that finds the store empty sets `udf_flag`, and `rd_valid` stays 0.
- R9: `ovf_flag` and `udf_flag` stay set across any later traffic until a `resync` cycle or reset clears them.
- R10: Read and write positions wrap modulo DEPTH, so streams longer than DEPTH keep their order when reads keep pace with writes.
- R11: Once the read side is serving, a further `frame_ref` pulse or a change of `map_offset` has no effect until the next `resync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Sample present on `wr_data` |
| wr_data | input | DATA_W (32) | Sample from the data source |
| resync | input | 1 | Restart the buffer at slot zero |
| rd_req | input | 1 | Word strobe from the frame mapper |
| map_offset | input | OFS_W (8) | Number of strobes to let pass after `frame_ref` |
| frame_ref | input | 1 | Frame-reference pulse that arms the read side |
| rd_valid | output | 1 | `rd_data` holds a newly read sample |
| rd_data | output | DATA_W (32) | Sample toward the mapper |
| ovf_flag | output | 1 | Sticky overflow indication |
| udf_flag | output | 1 | Sticky underflow indication |

## Verification
The assertions assume that `resync`, `frame_ref` and `rd_req` are single-cycle level inputs sampled at the clock. They also assume that `map_offset` does not change while the read side is counting strobes, because the skip comparison reads it live. The stimulus changes `map_offset` only before a `frame_ref` pulse or after reads have started, where R11 says it is ignored. The sweep arms the read side only after each burst has been written, so every expected sample and flag follows from the write count and the offset alone.

// File: rtl/axcbuf_pkg.sv
package axcbuf_pkg;

  typedef enum logic [1:0] {
    GATE_IDLE  = 2'd0,
    GATE_COUNT = 2'd1,
    GATE_OPEN  = 2'd2
  } gate_state_t;

  // next slot index, wrapping at depth
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // occupancy after one cycle of optional add and remove
  function automatic int unsigned level_next(int unsigned lvl, logic add, logic sub);
    int unsigned v;
    v = lvl;
    if (add) v = v + 1;
    if (sub) v = v - 1;
    return v;
  endfunction

  // true when the strobe count has reached the programmed offset
  function automatic logic skip_done(int unsigned cnt, int unsigned ofs);
    return cnt == ofs;
  endfunction

endpackage

// File: rtl/axcbuf_store.sv
module axcbuf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= slots[rd_addr];
    end
  end

endmodule

// File: rtl/axcbuf_gate.sv
module axcbuf_gate
  import axcbuf_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync,
  input  logic             frame_ref,
  input  logic             rd_req,
  input  logic [OFS_W-1:0] map_offset,
  output logic             rd_accept
);

  gate_state_t      state;
  logic [OFS_W-1:0] skip_cnt;
  logic             hit;
  logic             pass;

  assign hit  = skip_done(32'(skip_cnt), 32'(map_offset));
  assign pass = (state == GATE_OPEN) ||
                (state == GATE_COUNT && !frame_ref && hit);
  assign rd_accept = rd_req && pass && !resync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= GATE_IDLE;
      skip_cnt <= '0;
    end else if (resync) begin
      state    <= GATE_IDLE;
      skip_cnt <= '0;
    end else begin
      unique case (state)
        GATE_IDLE: begin
          if (frame_ref) begin
            state    <= GATE_COUNT;
            skip_cnt <= '0;
          end
        end
        GATE_COUNT: begin
          if (frame_ref) begin
            skip_cnt <= '0;
          end else if (rd_req) begin
            if (hit) state <= GATE_OPEN;
            else     skip_cnt <= skip_cnt + OFS_W'(1);
          end
        end
        GATE_OPEN: state <= GATE_OPEN;
        default:   state <= GATE_IDLE;
      endcase
    end
  end

  // R11
  open_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GATE_OPEN && !resync) |=> (state == GATE_OPEN));

  // R4
  resync_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (state == GATE_IDLE));

  // R5
  idle_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GATE_IDLE) |-> !rd_accept);

endmodule

// File: rtl/axcbuf_ctrl.sv
module axcbuf_ctrl
  import axcbuf_pkg::*;
#(
  parameter int DEPTH  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             resync,
  input  logic             rd_accept,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic             rd_en,
  output logic [PTR_W-1:0] rd_addr,
  output logic             ovf_flag,
  output logic             udf_flag
);

  logic [PTR_W-1:0] wptr, rptr;
  logic [LVL_W-1:0] level;
  logic             full, empty;
  logic             wr_drop, rd_starve;

  assign full      = (32'(level) == DEPTH);
  assign empty     = (level == '0);
  assign rd_en     = rd_accept && !empty;
  assign rd_starve = rd_accept && empty;
  assign wr_en     = wr_valid && (resync || !full || rd_en);
  assign wr_drop   = wr_valid && !wr_en;
  assign wr_addr   = resync ? '0 : wptr;
  assign rd_addr   = rptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      level    <= '0;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else if (resync) begin
      wptr     <= wr_valid ? PTR_W'(wrap_inc(0, DEPTH)) : '0;
      rptr     <= '0;
      level    <= wr_valid ? LVL_W'(1) : '0;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else begin
      if (wr_en) wptr <= PTR_W'(wrap_inc(32'(wptr), DEPTH));
      if (rd_en) rptr <= PTR_W'(wrap_inc(32'(rptr), DEPTH));
      level    <= LVL_W'(level_next(32'(level), wr_en, rd_en));
      ovf_flag <= ovf_flag | wr_drop;
      udf_flag <= udf_flag | rd_starve;
    end
  end

  // R3
  resync_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resync && wr_valid) |=> (level == LVL_W'(1) && !ovf_flag && !udf_flag));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !resync) |=> ovf_flag);

  // R9
  udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_flag && !resync) |=> udf_flag);

  // R7
  drop_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> (ovf_flag && level == $past(level)));

  // R8
  starve_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && level == '0) |=> udf_flag);

  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);

endmodule

// File: rtl/axc_tx_buffer.sv
module axc_tx_buffer #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int OFS_W  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              resync,
  input  logic              rd_req,
  input  logic [OFS_W-1:0]  map_offset,
  input  logic              frame_ref,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              ovf_flag,
  output logic              udf_flag
);

  logic             rd_accept;
  logic             wr_en, rd_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;

  axcbuf_gate #(.OFS_W(OFS_W)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .resync     (resync),
    .frame_ref  (frame_ref),
    .rd_req     (rd_req),
    .map_offset (map_offset),
    .rd_accept  (rd_accept)
  );

  axcbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .resync    (resync),
    .rd_accept (rd_accept),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .ovf_flag  (ovf_flag),
    .udf_flag  (udf_flag)
  );

  axcbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // R5
  gate_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_accept |-> !rd_en);

  // R6
  read_valid_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R8
  empty_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && !rd_en) |=> !rd_valid);

endmodule

// File: tb/axc_tx_buffer_test.sv
module axc_tx_buffer_test;

  localparam int DW = 32;
  localparam int DP = 8;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          resync = 1'b0;
  logic          rd_req = 1'b0;
  logic [OW-1:0] map_offset = '0;
  logic          frame_ref = 1'b0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          ovf_flag, udf_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  axc_tx_buffer #(.DATA_W(DW), .DEPTH(DP), .OFS_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .resync(resync), .rd_req(rd_req), .map_offset(map_offset),
    .frame_ref(frame_ref), .rd_valid(rd_valid), .rd_data(rd_data),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_resync(input logic v, input logic [DW-1:0] d);
    resync = 1'b1; wr_valid = v; wr_data = d;
    cyc();
    resync = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    wr_valid = 1'b1; wr_data = d;
    cyc();
    wr_valid = 1'b0;
  endtask

  task automatic do_frame();
    frame_ref = 1'b1;
    cyc();
    frame_ref = 1'b0;
  endtask

  task automatic do_strobe();
    rd_req = 1'b1;
    cyc();
    rd_req = 1'b0;
  endtask

  function automatic logic [31:0] pat(int k, int n, int i);
    return 32'hA500_0000 | (32'(k) << 16) | (32'(n) << 8) | 32'(i);
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    chk("R1 rd_valid", 32'(rd_valid), 0);
    chk("R1 ovf", 32'(ovf_flag), 0);
    chk("R1 udf", 32'(udf_flag), 0);
    do_write(32'h1111_0000);
    do_strobe();
    chk("R1 unarmed strobe valid", 32'(rd_valid), 0);
    chk("R1 unarmed strobe udf", 32'(udf_flag), 0);

    // R2 R3 R5 R6 R8 R9 sweep over offset and fill count
    for (int k = 0; k < 4; k++) begin
      for (int n = 1; n <= DP; n++) begin
        map_offset = OW'(k);
        do_resync(1'b1, pat(k, n, 0));
        chk("R9 flags cleared by resync", {30'd0, ovf_flag, udf_flag}, 0);
        for (int i = 1; i < n; i++) do_write(pat(k, n, i));
        do_frame();
        for (int s = 0; s < k; s++) begin
          do_strobe();
          chk("R5 skipped strobe", {30'd0, rd_valid, udf_flag}, 0);
        end
        for (int i = 0; i < n; i++) begin
          do_strobe();
          chk("R6 rd_valid", 32'(rd_valid), 1);
          chk("R2 R3 order", rd_data, pat(k, n, i));
        end
        do_strobe();
        chk("R8 empty valid", 32'(rd_valid), 0);
        chk("R8 udf set", 32'(udf_flag), 1);
        chk("R7 no ovf", 32'(ovf_flag), 0);
        do_write(pat(k, n, 99));
        chk("R9 udf held", 32'(udf_flag), 1);
      end
    end

    // R3 resync without data: next write lands in slot zero; R10 wrap
    map_offset = '0;
    do_resync(1'b0, 32'hDEAD_BEEF);
    do_frame();
    for (int i = 0; i < 6; i++) do_write(32'h5000_0000 + 32'(i));
    for (int i = 0; i < 5; i++) begin
      do_strobe();
      chk("R3 R10 first pass", rd_data, 32'h5000_0000 + 32'(i));
    end
    for (int i = 6; i < 12; i++) do_write(32'h5000_0000 + 32'(i));
    chk("R10 no ovf at wrap", 32'(ovf_flag), 0);
    for (int i = 5; i < 12; i++) begin
      do_strobe();
      chk("R10 wrapped order", rd_data, 32'h5000_0000 + 32'(i));
    end
    chk("R10 no udf", 32'(udf_flag), 0);

    // R7 overflow, R9 stickiness
    map_offset = OW'(2);
    do_resync(1'b1, 32'h7000_0000);
    for (int i = 1; i < DP; i++) do_write(32'h7000_0000 + 32'(i));
    chk("R7 full no ovf", 32'(ovf_flag), 0);
    do_write(32'h7000_00FF);
    chk("R7 ovf set", 32'(ovf_flag), 1);
    do_frame();
    do_strobe();
    do_strobe();
    for (int i = 0; i < DP; i++) begin
      do_strobe();
      chk("R7 kept data", rd_data, 32'h7000_0000 + 32'(i));
    end
    chk("R9 ovf held", 32'(ovf_flag), 1);
    do_strobe();
    chk("R8 udf after drain", 32'(udf_flag), 1);
    do_resync(1'b0, '0);
    chk("R9 cleared", {30'd0, ovf_flag, udf_flag}, 0);

    // R4 resync discards unread data and disarms reads
    map_offset = '0;
    do_resync(1'b1, 32'h0000_0044);
    do_write(32'h0000_0045);
    do_write(32'h0000_0046);
    do_frame();
    do_strobe();
    chk("R4 pre read", rd_data, 32'h0000_0044);
    do_resync(1'b1, 32'h0000_0077);
    do_strobe();
    chk("R4 disarmed", {30'd0, rd_valid, udf_flag}, 0);
    do_frame();
    do_strobe();
    chk("R4 fresh data", rd_data, 32'h0000_0077);
    chk("R4 valid", 32'(rd_valid), 1);

    // R11 frame_ref and offset ignored once serving
    do_write(32'h0000_0078);
    map_offset = OW'(3);
    do_frame();
    do_strobe();
    chk("R11 still serving", 32'(rd_valid), 1);
    chk("R11 data", rd_data, 32'h0000_0078);
    do_strobe();
    chk("R8 final udf", 32'(udf_flag), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule